// File: doc/BRIEF.md
# Target-Addressed Command Bus

This block links one processor-side requester to three peripheral units over a shared command bus. The processor hands over a 32-bit command word and a 32-bit data word together with a one-cycle ready strobe. The master side copies both onto the shared bus lines and raises a request. It holds them steady until a slave acknowledges. If no slave answers in time, it gives up. It then reports the result to the processor as a one-cycle completion strobe or a one-cycle error strobe.

The top four bits of the command word name the destination. There is no central address decoder. Each slave interface carries its own 4-bit identifier, set by a parameter at instantiation, and compares it with the top field of the shared command lines. The matching interface acknowledges the request. It gives its local unit the lower 28 command bits and the data word, marked by a one-cycle valid pulse. By default the three identifiers are 1, 2 and 3 for slave outputs 0, 1 and 2.

Top module: `tbus_fabric`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_req, bus_ack, cpu_done, cpu_err and all slv_valid bits are 0.
- R2: Command bits [31:28] select the target. The slave whose identifier equals that field (defaults: 1 for slave 0, 2 for slave 1, 3 for slave 2) receives command bits [27:0] on its 28-bit lane of slv_cmd and the data word on its 32-bit lane of slv_data. Lane i occupies bits [i*28 +: 28] and [i*32 +: 32].
- R3: Only the addressed slave reacts. The other slaves' valid bits stay low and their cmd/data lanes keep their previous values. At most one slv_valid bit is high in any cycle.
- R4: When cpu_rdy is sampled high with the master idle, bus_req is high in the next cycle. The bus command and data stay unchanged for as long as bus_req stays high.
- R5: Each accepted request gives exactly one single-cycle pulse on the addressed slave's valid bit, one cycle after bus_req rises.
- R6: For a matched target, cpu_done is high for exactly one cycle, two cycles after the ready edge. cpu_err stays low.
- R7: If no slave matches, the master drops bus_req and pulses cpu_err for one cycle, 16 cycles after the ready edge. cpu_done stays low and no slave valid bit rises.
- R8: cpu_done and cpu_err are never high in the same cycle.
- R9: bus_ack falls in the cycle after bus_req is removed. cpu_rdy pulses that arrive while a transfer or its acknowledge drain is still in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cmd | input | 32 | Command word: target field in [31:28], payload in [27:0] |
| cpu_data | input | 32 | Data word sent with the command |
| cpu_rdy | input | 1 | Processor strobe: command and data are valid |
| cpu_done | output | 1 | One-cycle strobe: a slave accepted the transfer |
| cpu_err | output | 1 | One-cycle strobe: no slave answered before the timeout |
| bus_req | output | 1 | Shared bus request, driven by the master |
| bus_ack | output | 1 | OR of all slave acknowledges |
| slv_valid | output | 3 | Per-slave one-cycle command-valid pulse |
| slv_cmd | output | 84 | Per-slave 28-bit command payload, lane i at [i*28 +: 28] |
| slv_data | output | 96 | Per-slave 32-bit data word, lane i at [i*32 +: 32] |

## Verification
Some properties must hold in every cycle, and assertions check them on each edge: bus lines stay stable while the request is held, the valid and done strobes last one cycle, done and error never coincide, acknowledge drops after the request goes away, and no two slaves are strobed together. Other behaviour shows only across a whole scenario. The bench covers these: the exact latency of done and of the timeout, delivery of the right payload and data to the right lane, unchanged lanes on the slaves that were not addressed, and a second ready pulse during a transfer being dropped.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

    localparam int CMD_W  = 32;
    localparam int TGT_W  = 4;
    localparam int PAY_W  = CMD_W - TGT_W;
    localparam int DATA_W = 32;

    typedef logic [TGT_W-1:0]  tgt_t;
    typedef logic [PAY_W-1:0]  pay_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        tgt_t tgt;
        pay_t pay;
    } cmd_t;

    typedef struct packed {
        cmd_t  cmd;
        word_t data;
    } xfer_t;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_WAIT  = 2'd1,
        M_DRAIN = 2'd2
    } mstate_e;

    function automatic logic tgt_hit(input cmd_t c, input tgt_t id);
        return c.tgt == id;
    endfunction

endpackage

// File: rtl/tbus_master.sv
module tbus_master
    import tbus_pkg::*;
#(
    parameter int TMO = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cpu_cmd,
    input  word_t cpu_data,
    input  logic  cpu_rdy,
    output logic  cpu_done,
    output logic  cpu_err,
    input  logic  bus_ack,
    output logic  bus_req,
    output xfer_t bus_x
);

    localparam int TW = $clog2(TMO) + 1;
    localparam logic [TW-1:0] TLAST = TW'(TMO - 1);

    mstate_e         state;
    logic [TW-1:0]   timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= M_IDLE;
            bus_x    <= '0;
            bus_req  <= 1'b0;
            cpu_done <= 1'b0;
            cpu_err  <= 1'b0;
            timer    <= '0;
        end else begin
            cpu_done <= 1'b0;
            cpu_err  <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (cpu_rdy) begin
                        bus_x   <= '{cmd: cpu_cmd, data: cpu_data};
                        bus_req <= 1'b1;
                        timer   <= '0;
                        state   <= M_WAIT;
                    end
                end
                M_WAIT: begin
                    if (bus_ack) begin
                        bus_req  <= 1'b0;
                        cpu_done <= 1'b1;
                        state    <= M_DRAIN;
                    end else if (timer == TLAST) begin
                        bus_req <= 1'b0;
                        cpu_err <= 1'b1;
                        state   <= M_IDLE;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                M_DRAIN: begin
                    if (!bus_ack) state <= M_IDLE;
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> $stable(bus_x)); // R4
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done); // R6
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cpu_done && cpu_err)); // R8
    AST_ERR_UNANSWERED: assert property (@(posedge clk) disable iff (rst)
        cpu_err |-> !$past(bus_ack)); // R7

endmodule

// File: rtl/tbus_slave_if.sv
module tbus_slave_if
    import tbus_pkg::*;
#(
    parameter tgt_t ID = 4'h1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bus_req,
    input  xfer_t bus_x,
    output logic  ack,
    output logic  valid,
    output pay_t  pay,
    output word_t data
);

    logic hit;
    logic take;

    assign hit  = bus_req && tgt_hit(bus_x.cmd, ID);
    assign take = hit && !ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            valid <= 1'b0;
            pay   <= '0;
            data  <= '0;
        end else begin
            ack   <= hit;
            valid <= take;
            if (take) begin
                pay  <= bus_x.cmd.pay;
                data <= bus_x.data;
            end
        end
    end

    AST_VALID_ONE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R5
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !ack); // R9
    AST_ACK_OWN_ID: assert property (@(posedge clk) disable iff (rst)
        ack |-> ($past(bus_x.cmd.tgt) == ID)); // R3

endmodule

// File: rtl/tbus_fabric.sv
module tbus_fabric
    import tbus_pkg::*;
#(
    parameter int NUM_SLV = 3,
    parameter int TMO     = 16,
    parameter logic [NUM_SLV*TGT_W-1:0] SLV_IDS = 12'h321
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CMD_W-1:0]          cpu_cmd,
    input  logic [DATA_W-1:0]         cpu_data,
    input  logic                      cpu_rdy,
    output logic                      cpu_done,
    output logic                      cpu_err,
    output logic                      bus_req,
    output logic                      bus_ack,
    output logic [NUM_SLV-1:0]        slv_valid,
    output logic [NUM_SLV*PAY_W-1:0]  slv_cmd,
    output logic [NUM_SLV*DATA_W-1:0] slv_data
);

    xfer_t              bus_x;
    logic [NUM_SLV-1:0] ack_vec;

    tbus_master #(.TMO(TMO)) u_master (
        .clk      (clk),
        .rst      (rst),
        .cpu_cmd  (cmd_t'(cpu_cmd)),
        .cpu_data (cpu_data),
        .cpu_rdy  (cpu_rdy),
        .cpu_done (cpu_done),
        .cpu_err  (cpu_err),
        .bus_ack  (bus_ack),
        .bus_req  (bus_req),
        .bus_x    (bus_x)
    );

    for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
        tbus_slave_if #(.ID(SLV_IDS[i*TGT_W +: TGT_W])) u_slv (
            .clk   (clk),
            .rst   (rst),
            .bus_req (bus_req),
            .bus_x (bus_x),
            .ack   (ack_vec[i]),
            .valid (slv_valid[i]),
            .pay   (slv_cmd[i*PAY_W +: PAY_W]),
            .data  (slv_data[i*DATA_W +: DATA_W])
        );
    end

    assign bus_ack = |ack_vec;

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slv_valid)); // R3
    AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_vec)); // R3

endmodule

// File: tb/test_tbus_fabric.sv
module test_tbus_fabric;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cpu_cmd;
    logic [31:0] cpu_data;
    logic        cpu_rdy;
    logic        cpu_done, cpu_err, bus_req, bus_ack;
    logic [2:0]  slv_valid;
    logic [83:0] slv_cmd;
    logic [95:0] slv_data;

    int checks = 0;
    int fails  = 0;
    int vcnt [3];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tbus_fabric i_tbus_fabric (
        .clk(clk), .rst(rst), .cpu_cmd(cpu_cmd), .cpu_data(cpu_data),
        .cpu_rdy(cpu_rdy), .cpu_done(cpu_done), .cpu_err(cpu_err),
        .bus_req(bus_req), .bus_ack(bus_ack), .slv_valid(slv_valid),
        .slv_cmd(slv_cmd), .slv_data(slv_data)
    );

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) vcnt[i] = 0;
        end else begin
            for (int i = 0; i < 3; i++) vcnt[i] = vcnt[i] + int'(slv_valid[i]);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [3:0] id);
        case (id)
            4'h1: return 0;
            4'h2: return 1;
            4'h3: return 2;
            default: return -1;
        endcase
    endfunction

    task automatic t_reset();
        rst = 1'b1; cpu_rdy = 1'b0; cpu_cmd = '0; cpu_data = '0;
        repeat (3) @(negedge clk);
        check(!bus_req && !bus_ack && !cpu_done && !cpu_err && slv_valid == 0,
              "R1", "outputs in reset", {bus_req, bus_ack, cpu_done, cpu_err, slv_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_req && !bus_ack && !cpu_done && !cpu_err && slv_valid == 0,
              "R1", "outputs after reset", {bus_req, bus_ack, cpu_done, cpu_err, slv_valid}, 0);
    endtask

    // One transfer; extra = second ready pulse during the transfer (R9)
    task automatic t_send(input logic [31:0] c, input logic [31:0] d,
                          input bit extra, input logic [31:0] c2);
        int s = slot_of(c[31:28]);
        int done_n = -1;
        int err_n = -1;
        int c0 [3];
        logic [83:0] cmd0 = slv_cmd;
        logic [95:0] dat0 = slv_data;
        for (int i = 0; i < 3; i++) c0[i] = vcnt[i];
        cpu_cmd = c; cpu_data = d; cpu_rdy = 1'b1;
        @(negedge clk);
        check(bus_req, "R4", "bus_req after ready", bus_req, 1);
        if (extra) begin
            cpu_cmd = c2; cpu_data = ~d;
        end else begin
            cpu_rdy = 1'b0;
        end
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            cpu_rdy = 1'b0;
            if (cpu_done && done_n < 0) done_n = n;
            if (cpu_err && err_n < 0) err_n = n;
            check(!(cpu_done && cpu_err), "R8", "done with err", {cpu_done, cpu_err}, 0);
            if (s >= 0 && n == 2)
                check(!bus_req && bus_ack, "R9", "req off, ack held", {bus_req, bus_ack}, 1);
            if (s >= 0 && n == 3)
                check(!bus_ack, "R9", "ack falls after req", bus_ack, 0);
        end
        if (s >= 0) begin
            check(done_n == 2, "R6", "done latency", done_n, 2);
            check(err_n == -1, "R6", "no err on match", err_n, -1);
            check(vcnt[s] - c0[s] == 1, "R5", "valid pulses", vcnt[s] - c0[s], 1);
            check(slv_cmd[s*28 +: 28] == c[27:0], "R2", "payload",
                  slv_cmd[s*28 +: 28], c[27:0]);
            check(slv_data[s*32 +: 32] == d, "R2", "data", slv_data[s*32 +: 32], d);
        end else begin
            check(err_n == 16, "R7", "timeout latency", err_n, 16);
            check(done_n == -1, "R7", "no done on miss", done_n, -1);
        end
        for (int i = 0; i < 3; i++) begin
            if (i != s) begin
                check(vcnt[i] == c0[i], "R3", "other slave strobed", vcnt[i] - c0[i], 0);
                check(slv_cmd[i*28 +: 28] == cmd0[i*28 +: 28] &&
                      slv_data[i*32 +: 32] == dat0[i*32 +: 32],
                      "R3", "other slave lane changed", slv_cmd[i*28 +: 28], cmd0[i*28 +: 28]);
            end
        end
        check(!bus_req && !bus_ack, "R9", "bus quiet after transfer", {bus_req, bus_ack}, 0);
    endtask

    initial begin
        t_reset();
        t_send(32'h1000_0ABC, 32'hDEAD_BEEF, 1'b0, '0);
        t_send(32'h2123_4567, 32'h0000_0001, 1'b0, '0);
        t_send(32'h3FFF_FFFF, 32'hFFFF_FFFF, 1'b0, '0);
        t_send(32'h1000_0000, 32'h8000_0000, 1'b0, '0);
        t_send(32'hF555_5555, 32'h1234_5678, 1'b0, '0);   // unused id
        t_send(32'h0AAA_AAAA, 32'h0BAD_F00D, 1'b0, '0);   // unused id
        t_send(32'h2ABC_DEF0, 32'hCAFE_0002, 1'b1, 32'h3000_0777); // overlap
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule